// File: doc/BRIEF.md
# Device Interrupt Pin Mapping Registers

This block holds the programmable table that decides which of eight shared interrupt request lines (PIRQ indices 0..7) each legacy INTx pin of a high-numbered device slot drives. Seven slots at the top of a 32-slot space (25 through 31) each own a 16-bit routing word in a small byte-addressed register window. Every INTx pin of such a slot takes a 4-bit field of that word. Slot 30 is a bridge whose mapping is wired and whose register always reads back zero. Every other slot, below 25, uses a rotating default mapping that only ever selects the upper four lines.

Software reaches the window through a simple request strobe that carries an address, a size of 1, 2 or 4 bytes and little-endian data. A separate base-address register places the window in the address space and switches decoding on or off. Interrupt routing logic elsewhere in the chip asks a combinational lookup port which line a given slot and pin drive.

Top module: `irq_pin_map`

## Requirements
- R1: After reset, every programmable slot word reads 16'h3210 (INTA..INTD to PIRQ 0..3), and the window is disabled.
- R2: Slot 30 reads as zero at its word (window offsets 10 and 11) and writes to it are discarded; its lookup always gives PIRQ 4 + pin (INTA..INTD to 4..7).
- R3: A lookup for a slot below 25 returns ((slot + pin) mod 4) + 4.
- R4: A lookup for programmable slot s (25..31, not 30) and pin p returns bits [4p+2:4p] of the word at window offset 2*(s-25); bit 4p+3 is ignored.
- R5: Data is little-endian: byte lane i of an access (bits [8i+7:8i]) maps to window offset off+i. req_size encodes 0 as 1 byte, 1 as 2 bytes, 2 or 3 as 4 bytes. Offsets 14 and 15 read zero and ignore writes.
- R6: The offset is the low 4 address bits; an access that would run past offset 15 is cut to the bytes that remain, never wrapping to offset 0, and clipped read lanes return zero.
- R7: An access hits only when address bits [31:4] equal the base field of the base register.
- R8: While the base register's enable bit (bit 0) is clear, reads give no response and writes change nothing.
- R9: A write shows on the lookup port from the cycle after its strobe.
- R10: A read that hits returns rd_valid with rd_data in the next cycle; no response appears without a read strobe in the previous cycle.
- R11: Writing the base register moves the window at once to base_wdata[31:4]; the old address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the base-address register |
| base_wdata | input | 32 | New base: bits [31:4] window base, bit 0 enable |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_wdata | input | 32 | Little-endian write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Little-endian read data |
| lk_slot | input | 5 | Slot number to look up |
| lk_pin | input | 2 | INTx pin, 0 = INTA |
| lk_pirq | output | 3 | PIRQ index driven by that pin |

## Verification
The lookup port is swept over all 32 slots and 4 pins both at reset defaults and after every programmable word has been written with patterns whose nibbles set the ignored top bit, which separates the three mapping kinds and shows whether the top bit leaks in. Single-byte reads of every offset, word reads, and a misaligned halfword tell lane order apart from word order. Accesses at offsets 12 through 15 with 4-byte size distinguish clipping from wrap-around, and accesses at a neighbouring 16-byte block, with the enable clear, and after rebasing show the decode gating.

// File: rtl/irq_pin_map_pkg.sv
package irq_pin_map_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WIDE = 2'd3
  } acc_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      ACC_BYTE: size_bytes = 3'd1;
      ACC_HALF: size_bytes = 3'd2;
      default:  size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ipm_window_decode.sv
module ipm_window_decode
  import irq_pin_map_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              win_en,
  output logic              win_hit,
  output logic [WIN_AW-1:0] win_off,
  output logic [3:0]        lane_en
);
  localparam int WIN_BYTES = 1 << WIN_AW;
  localparam int REM_W     = WIN_AW + 1;

  logic [ADDR_W-1:WIN_AW] base_q;
  logic                   en_q;
  logic [2:0]             nbytes;
  logic [REM_W-1:0]       remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else if (base_we) begin
      base_q <= base_wdata[ADDR_W-1:WIN_AW];
      en_q   <= base_wdata[0];
    end
  end

  logic unused_base_bits;
  assign unused_base_bits = ^base_wdata[WIN_AW-1:1];

  assign win_en  = en_q;
  assign win_hit = en_q && (req_addr[ADDR_W-1:WIN_AW] == base_q);
  assign win_off = req_addr[WIN_AW-1:0];
  assign nbytes  = size_bytes(req_size);
  assign remain  = REM_W'(WIN_BYTES) - REM_W'(win_off);

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_en[i] = (3'(i) < nbytes) && (REM_W'(i) < remain);
  end

endmodule

// File: rtl/ipm_route_store.sv
module ipm_route_store #(
  parameter int          WIN_AW       = 4,
  parameter int          PROG_SLOTS   = 7,
  parameter int          FIXED_IDX    = 5,
  parameter int          ROUTE_OFF    = 0,
  parameter logic [15:0] DEFAULT_WORD = 16'h3210
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [WIN_AW-1:0]           off,
  input  logic [3:0]                  lane_en,
  input  logic [31:0]                 wdata,
  output logic                        rd_valid,
  output logic [31:0]                 rd_data,
  output logic [PROG_SLOTS-1:0][15:0] route_words
);
  localparam int NBYTES = PROG_SLOTS * 2;

  logic [3:0][NBYTES-1:0] sel;
  logic [7:0]             bytes_w [NBYTES];
  logic [31:0]            rd_next;

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      for (int b = 0; b < NBYTES; b++) begin
        sel[l][b] = lane_en[l] && ((int'(off) + l) == (ROUTE_OFF + b));
      end
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if ((b / 2) == FIXED_IDX) begin : g_fixed
      assign bytes_w[b] = 8'h00;
    end else begin : g_prog
      localparam logic [7:0] RST_BYTE = DEFAULT_WORD[8*(b%2) +: 8];
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= RST_BYTE;
        end else if (wr_en) begin
          for (int l = 0; l < 4; l++) begin
            if (sel[l][b]) q <= wdata[8*l +: 8];
          end
        end
      end
      assign bytes_w[b] = q;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int l = 0; l < 4; l++) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (sel[l][b]) rd_next[8*l +: 8] = rd_next[8*l +: 8] | bytes_w[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  for (genvar k = 0; k < PROG_SLOTS; k++) begin : g_word
    assign route_words[k] = {bytes_w[2*k+1], bytes_w[2*k]};
  end

endmodule

// File: rtl/ipm_lookup.sv
module ipm_lookup #(
  parameter int SLOT_W     = 5,
  parameter int FIRST_SLOT = 25,
  parameter int PROG_SLOTS = 7,
  parameter int FIXED_IDX  = 5,
  parameter int FIELD_W    = 4,
  parameter int PIRQ_W     = 3
) (
  input  logic [PROG_SLOTS-1:0][15:0] route_words,
  input  logic [SLOT_W-1:0]           lk_slot,
  input  logic [1:0]                  lk_pin,
  output logic [PIRQ_W-1:0]           lk_pirq
);
  localparam int HALF = 1 << (PIRQ_W - 1);

  logic unused_route;
  assign unused_route = ^route_words;

  always_comb begin
    lk_pirq = PIRQ_W'(HALF) + PIRQ_W'((int'(lk_slot) + int'(lk_pin)) % HALF);
    for (int k = 0; k < PROG_SLOTS; k++) begin
      if (int'(lk_slot) == FIRST_SLOT + k) begin
        if (k == FIXED_IDX) begin
          lk_pirq = PIRQ_W'(HALF) + PIRQ_W'(lk_pin);
        end else begin
          lk_pirq = route_words[k][int'(lk_pin)*FIELD_W +: PIRQ_W];
        end
      end
    end
  end

endmodule

// File: rtl/irq_pin_map.sv
module irq_pin_map #(
  parameter int          ADDR_W       = 32,
  parameter int          WIN_AW       = 4,
  parameter int          SLOT_W       = 5,
  parameter int          FIRST_SLOT   = 25,
  parameter int          FIXED_SLOT   = 30,
  parameter int          ROUTE_OFF    = 0,
  parameter int          FIELD_W      = 4,
  parameter int          PIRQ_W       = 3,
  parameter logic [15:0] DEFAULT_WORD = 16'h3210
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [1:0]        lk_pin,
  output logic [PIRQ_W-1:0] lk_pirq
);
  localparam int PROG_SLOTS = (1 << SLOT_W) - FIRST_SLOT;
  localparam int FIXED_IDX  = FIXED_SLOT - FIRST_SLOT;

  logic                        win_en;
  logic                        win_hit;
  logic [WIN_AW-1:0]           win_off;
  logic [3:0]                  lane_en;
  logic [PROG_SLOTS-1:0][15:0] route_words;
  logic                        wr_en;
  logic                        rd_en;

  assign wr_en = req_valid && req_write && win_hit;
  assign rd_en = req_valid && !req_write && win_hit;

  ipm_window_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_dec (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_addr(req_addr), .req_size(req_size), .win_en(win_en),
    .win_hit(win_hit), .win_off(win_off), .lane_en(lane_en)
  );

  ipm_route_store #(
    .WIN_AW(WIN_AW), .PROG_SLOTS(PROG_SLOTS), .FIXED_IDX(FIXED_IDX),
    .ROUTE_OFF(ROUTE_OFF), .DEFAULT_WORD(DEFAULT_WORD)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .off(win_off),
    .lane_en(lane_en), .wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .route_words(route_words)
  );

  ipm_lookup #(
    .SLOT_W(SLOT_W), .FIRST_SLOT(FIRST_SLOT), .PROG_SLOTS(PROG_SLOTS),
    .FIXED_IDX(FIXED_IDX), .FIELD_W(FIELD_W), .PIRQ_W(PIRQ_W)
  ) u_lk (
    .route_words(route_words), .lk_slot(lk_slot), .lk_pin(lk_pin),
    .lk_pirq(lk_pirq)
  );

endmodule

// File: rtl/ipm_checker.sv
module ipm_checker #(
  parameter int SLOT_W     = 5,
  parameter int FIRST_SLOT = 25,
  parameter int FIXED_SLOT = 30,
  parameter int PIRQ_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              win_en,
  input logic              win_hit,
  input logic              rd_valid,
  input logic [SLOT_W-1:0] lk_slot,
  input logic [1:0]        lk_pin,
  input logic [PIRQ_W-1:0] lk_pirq
);
  localparam int HALF = 1 << (PIRQ_W - 1);

  // R2
  fixed_slot_map_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(lk_slot) == FIXED_SLOT) |-> (lk_pirq == PIRQ_W'(HALF) + PIRQ_W'(lk_pin)));

  // R3
  default_upper_half_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(lk_slot) < FIRST_SLOT) |-> lk_pirq[PIRQ_W-1]);

  // R10
  rd_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_write));

  // R10
  read_answers_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && win_hit) |=> rd_valid);

  // R8
  disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !win_en) |=> !rd_valid);

  // R9
  lookup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(req_valid && req_write) && $stable(lk_slot) && $stable(lk_pin))
      |-> $stable(lk_pirq));

endmodule

bind irq_pin_map ipm_checker #(
  .SLOT_W(SLOT_W), .FIRST_SLOT(FIRST_SLOT), .FIXED_SLOT(FIXED_SLOT), .PIRQ_W(PIRQ_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .win_en(win_en), .win_hit(win_hit), .rd_valid(rd_valid),
  .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
);

// File: tb/tb_irq_pin_map.sv
`timescale 1ns/1ps
module tb_irq_pin_map;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] mem_m [16];

  always #2.5 clk = ~clk;

  irq_pin_map dut (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit stored(input int o);
    return (o < 14) && (o != 10) && (o != 11);
  endfunction

  task automatic model_write(input int off, input logic [1:0] sz, input logic [31:0] d);
    for (int i = 0; i < nbytes(sz); i++)
      if (off + i < 16 && stored(off + i)) mem_m[off+i] = d[8*i +: 8];
  endtask

  function automatic logic [31:0] model_read(input int off, input logic [1:0] sz);
    logic [31:0] r = '0;
    for (int i = 0; i < nbytes(sz); i++)
      if (off + i < 16 && stored(off + i)) r[8*i +: 8] = mem_m[off+i];
    return r;
  endfunction

  function automatic logic [2:0] exp_pirq(input int s, input int p);
    logic [15:0] w;
    if (s == 30) return 3'(4 + p);
    if (s >= 25) begin
      w = {mem_m[2*(s-25)+1], mem_m[2*(s-25)]};
      return w[4*p +: 3];
    end
    return 3'(((s + p) % 4) + 4);
  endfunction

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [1:0] sz,
                          output logic v, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    v = rd_valid; d = rd_data;
    req_valid = 1'b0;
  endtask

  task automatic sweep_lookup(input string tag);
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        lk_slot = 5'(s); lk_pin = 2'(p);
        #1;
        chk($sformatf("%s slot=%0d pin=%0d", tag, s, p), 32'(lk_pirq), 32'(exp_pirq(s, p)));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic        v;
    logic [31:0] d;
    for (int k = 0; k < 7; k++) begin
      mem_m[2*k]   = (k == 5) ? 8'h00 : 8'h10;
      mem_m[2*k+1] = (k == 5) ? 8'h00 : 8'h32;
    end
    mem_m[14] = 8'h00; mem_m[15] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R8: window disabled after reset
    bus_read(32'h1000, 2'd2, v, d);
    chk("R1 R8 reset window disabled", 32'(v), 0);

    // R1 R2 R3 R4: lookup at defaults
    sweep_lookup("R1 R2 R3 default lookup");

    set_base(32'h0000_1001);
    // R1 R5: byte reads of every offset
    for (int o = 0; o < 16; o++) begin
      bus_read(32'h1000 + 32'(o), 2'd0, v, d);
      chk($sformatf("R10 valid off=%0d", o), 32'(v), 1);
      chk($sformatf("R1 R5 byte off=%0d", o), d, model_read(o, 2'd0));
    end

    // R2 R4 R9: write every slot word, lookup next cycle
    for (int k = 0; k < 7; k++) begin
      logic [15:0] w = 16'h9ABC + 16'(k) * 16'h1357;
      bus_write(32'h1000 + 32'(2*k), 2'd1, {16'h0, w});
      model_write(2*k, 2'd1, {16'h0, w});
      for (int p = 0; p < 4; p++) begin
        lk_slot = 5'(25 + k); lk_pin = 2'(p);
        #1;
        chk($sformatf("R9 R4 slot=%0d pin=%0d", 25 + k, p), 32'(lk_pirq), 32'(exp_pirq(25 + k, p)));
      end
    end
    bus_read(32'h100A, 2'd1, v, d);
    chk("R2 slot30 reads zero", d, 32'h0);
    sweep_lookup("R2 R3 R4 programmed lookup");

    // R5: word and misaligned reads
    for (int o = 0; o < 16; o += 4) begin
      bus_read(32'h1000 + 32'(o), 2'd2, v, d);
      chk($sformatf("R5 word off=%0d", o), d, model_read(o, 2'd2));
    end
    bus_read(32'h1001, 2'd1, v, d);
    chk("R5 misaligned half", d, model_read(1, 2'd1));
    bus_read(32'h1004, 2'd3, v, d);
    chk("R5 size3 is word", d, model_read(4, 2'd3));

    // R6: clipping at the window end
    bus_write(32'h100E, 2'd2, 32'hDEAD_BEEF);
    bus_read(32'h1000, 2'd2, v, d);
    chk("R6 no wrap on write", d, model_read(0, 2'd2));
    bus_write(32'h100C, 2'd2, 32'h1122_3344);
    model_write(12, 2'd2, 32'h1122_3344);
    bus_read(32'h100D, 2'd2, v, d);
    chk("R6 clipped read", d, model_read(13, 2'd2));
    bus_read(32'h1000, 2'd2, v, d);
    chk("R6 slot25 intact", d, model_read(0, 2'd2));

    // R7: neighbouring block misses
    bus_read(32'h1010, 2'd0, v, d);
    chk("R7 neighbour miss", 32'(v), 0);
    bus_write(32'h1010, 2'd1, 32'h0000_7777);
    bus_read(32'h1000, 2'd1, v, d);
    chk("R7 neighbour write ignored", d, model_read(0, 2'd1));

    // R8: disabled window
    set_base(32'h0000_1000);
    bus_write(32'h1000, 2'd1, 32'h0000_5555);
    lk_slot = 5'd25; lk_pin = 2'd0; #1;
    chk("R8 disabled write no lookup change", 32'(lk_pirq), 32'(exp_pirq(25, 0)));
    bus_read(32'h1000, 2'd1, v, d);
    chk("R8 disabled no response", 32'(v), 0);

    // R11: rebase
    set_base(32'h0000_2001);
    bus_read(32'h1000, 2'd1, v, d);
    chk("R11 old base misses", 32'(v), 0);
    bus_read(32'h2000, 2'd1, v, d);
    chk("R11 new base hits", 32'(v), 1);
    chk("R8 R11 data unchanged", d, model_read(0, 2'd1));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule